// File: doc/BRIEF.md
# Event Counter Bank with Overflow Halt

This block holds six programmable event counters, each 48 bits wide. Every clock cycle each counter can take an increment of zero to five units from its own event input. Each counter has an enable bit and an interrupt-enable bit of its own. A counter advances only when its enable bit is set, the upstream global enable is high, and no freeze is in force.

When a counter passes its top value, it keeps the low 48 bits of the sum and sets its bit in a sticky status register. The block drives an overflow line to an upstream collector. If that counter's interrupt-enable bit is set, the block also raises an interrupt request. Any overflow halts every counter from the next cycle onward. Counting starts again only after two things happen: software has cleared all status bits through a write-one-to-clear register, and the global enable has been seen low and then high again.

Software uses a plain register port. It can preload or read counters, set the per-counter controls, read the status and clear overflow bits. The event inputs and the freeze input are per-cycle levels. There is no valid/ready handshake, and no input can be back-pressured. Every pin is a plain control or data level.

Top module: `evmon_bank`

## Requirements
- R1: After reset every counter, every control field and the status register read as zero, and `ovf_out` and `irq_out` are low.
- R2: An enabled counter adds its increment input on every counting cycle. A read strobe for address i (0 to 5) returns counter i on `reg_rdata` one cycle later.
- R3: An increment value above 5 (the codes 6 and 7) is counted as 5.
- R4: A counter advances only when bit 0 (enable) of its control register at address 6+i is set and `glb_en` is high. Otherwise it holds its value.
- R5: While `freeze_in` is high, all counters hold their values. Register reads still return current contents.
- R6: A write to address i loads counter i and does not set any status bit. The write takes priority over an increment in the same cycle.
- R7: When an increment carries counter i past 2^48-1, the counter keeps the low 48 bits of the sum and sets bit i of the status register at address 12. The bit stays set until software clears it.
- R8: `ovf_out` is the OR of all status bits. `irq_out` is the OR of the status bits whose counter has bit 1 (interrupt enable) of its control register set.
- R9: From the cycle after any overflow, no counter advances.
- R10: Writing 1 to bit i of address 13 clears status bit i. Counting resumes only after all status bits are zero and `glb_en` has been low for at least one cycle and then high.
- R11: If an overflow of counter i and a clear of bit i happen in the same cycle, the status bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| glb_en | input | 1 | Global count enable from the upstream controller |
| freeze_in | input | 1 | Freeze request; all counters hold while it is high |
| event_inc | input | 18 | Six 3-bit increments; counter i uses bits [3i+2:3i] |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address: 0-5 counters, 6-11 controls, 12 status, 13 clear |
| reg_wdata | input | 48 | Register write data |
| reg_rdata | output | 48 | Read data, valid one cycle after the read strobe |
| ovf_out | output | 1 | Overflow notification to the upstream collector |
| irq_out | output | 1 | Interrupt request to the upstream controller |

## Verification
Counter values, status bits and both outputs change at the rising edge that consumes an increment, a write or a clear. Read data appears at the rising edge after the read strobe. The internal halt blocks counting from the edge after an overflow. The bench drives every input just after a falling edge and checks the outputs at the next falling edge. It checks a register value one cycle after the strobe that requested it. A scoreboard queue pairs each read with the value the requirements predict. Each scenario uses separate cycles for control writes and increments, because a control write takes effect only at the following edge.

// File: rtl/evmon_pkg.sv
package evmon_pkg;
  // per-counter control field, bit 1 = interrupt enable, bit 0 = count enable
  typedef struct packed {
    logic pmi_en;
    logic en;
  } ctl_t;
  localparam int CTL_W = 2;
endpackage

// File: rtl/evmon_ctr.sv
module evmon_ctr
  import evmon_pkg::*;
#(
  parameter int CTR_W   = 48,
  parameter int INC_W   = 3,
  parameter int MAX_INC = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             ctr_wr_i,
  input  logic             ctl_wr_i,
  input  logic [CTR_W-1:0] wdata_i,
  input  logic [INC_W-1:0] inc_i,
  output logic [CTR_W-1:0] cnt_o,
  output ctl_t             ctl_o,
  output logic             wrap_o
);
  localparam int SUM_W = CTR_W + 1;

  logic [INC_W-1:0] inc_eff;
  logic [SUM_W-1:0] sum;
  logic             active;

  always_comb begin
    inc_eff = (inc_i > INC_W'(MAX_INC)) ? INC_W'(MAX_INC) : inc_i;
    sum     = {1'b0, cnt_o} + {{(SUM_W-INC_W){1'b0}}, inc_eff};
    active  = run_i & ctl_o.en & ~ctr_wr_i;
    wrap_o  = active & sum[CTR_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_o <= '0;
      ctl_o <= '0;
    end else begin
      if (ctr_wr_i)    cnt_o <= wdata_i;
      else if (active) cnt_o <= sum[CTR_W-1:0];
      if (ctl_wr_i)    ctl_o <= ctl_t'(wdata_i[CTL_W-1:0]);
    end
  end

  // R4
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctr_wr_i && !(run_i && ctl_o.en)) |=> $stable(cnt_o));
  // R6
  preload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctr_wr_i |=> (cnt_o == $past(wdata_i)));
  // R3
  inc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctr_wr_i |=> (CTR_W'(cnt_o - $past(cnt_o)) <= CTR_W'(MAX_INC)));
endmodule

// File: rtl/evmon_stat.sv
module evmon_stat #(
  parameter int NUM_CTR = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CTR-1:0] wrap_i,
  input  logic               clr_we_i,
  input  logic [NUM_CTR-1:0] clr_mask_i,
  input  logic [NUM_CTR-1:0] pmi_i,
  input  logic               glb_en_i,
  output logic [NUM_CTR-1:0] status_o,
  output logic               frozen_o,
  output logic               ovf_o,
  output logic               irq_o
);
  logic [NUM_CTR-1:0] clr_eff;
  logic [NUM_CTR-1:0] status_d;
  logic               frozen_d;

  always_comb begin
    clr_eff  = clr_we_i ? clr_mask_i : '0;
    // a new wrap beats a clear of the same bit
    status_d = (status_o & ~clr_eff) | wrap_i;
    frozen_d = frozen_o;
    if (|wrap_i)                             frozen_d = 1'b1;
    else if ((status_o == '0) && !glb_en_i)  frozen_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_o <= '0;
      frozen_o <= 1'b0;
    end else begin
      status_o <= status_d;
      frozen_o <= frozen_d;
    end
  end

  assign ovf_o = |status_o;
  assign irq_o = |(status_o & pmi_i);

  for (genvar k = 0; k < NUM_CTR; k++) begin : g_chk
    // R7
    sticky_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o[k] && !(clr_we_i && clr_mask_i[k])) |=> status_o[k]);
    // R11
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_i[k] |=> status_o[k]);
  end
endmodule

// File: rtl/evmon_regif.sv
module evmon_regif
  import evmon_pkg::*;
#(
  parameter int NUM_CTR = 6,
  parameter int CTR_W   = 48,
  parameter int ADDR_W  = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          reg_wr_i,
  input  logic                          reg_rd_i,
  input  logic [ADDR_W-1:0]             reg_addr_i,
  input  logic [NUM_CTR-1:0][CTR_W-1:0] cnt_i,
  input  ctl_t [NUM_CTR-1:0]            ctl_i,
  input  logic [NUM_CTR-1:0]            status_i,
  output logic [NUM_CTR-1:0]            ctr_wr_o,
  output logic [NUM_CTR-1:0]            ctl_wr_o,
  output logic                          clr_we_o,
  output logic [CTR_W-1:0]              rdata_o
);
  localparam int CTL_BASE  = NUM_CTR;
  localparam int STAT_ADDR = 2 * NUM_CTR;
  localparam int CLR_ADDR  = 2 * NUM_CTR + 1;

  logic [CTR_W-1:0] rd_d;

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_dec
    assign ctr_wr_o[i] = reg_wr_i && (reg_addr_i == ADDR_W'(i));
    assign ctl_wr_o[i] = reg_wr_i && (reg_addr_i == ADDR_W'(CTL_BASE + i));
  end
  assign clr_we_o = reg_wr_i && (reg_addr_i == ADDR_W'(CLR_ADDR));

  always_comb begin
    rd_d = '0;
    for (int i = 0; i < NUM_CTR; i++) begin
      if (reg_addr_i == ADDR_W'(i))            rd_d = cnt_i[i];
      if (reg_addr_i == ADDR_W'(CTL_BASE + i)) rd_d = {{(CTR_W-CTL_W){1'b0}}, ctl_i[i]};
    end
    if (reg_addr_i == ADDR_W'(STAT_ADDR)) rd_d = {{(CTR_W-NUM_CTR){1'b0}}, status_i};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        rdata_o <= '0;
    else if (reg_rd_i) rdata_o <= rd_d;
  end
endmodule

// File: rtl/evmon_bank.sv
module evmon_bank
  import evmon_pkg::*;
#(
  parameter int NUM_CTR = 6,
  parameter int CTR_W   = 48,
  parameter int INC_W   = 3,
  parameter int MAX_INC = 5,
  parameter int ADDR_W  = $clog2(2 * NUM_CTR + 2)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     glb_en,
  input  logic                     freeze_in,
  input  logic [NUM_CTR*INC_W-1:0] event_inc,
  input  logic                     reg_wr,
  input  logic                     reg_rd,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [CTR_W-1:0]         reg_wdata,
  output logic [CTR_W-1:0]         reg_rdata,
  output logic                     ovf_out,
  output logic                     irq_out
);
  logic [NUM_CTR-1:0][CTR_W-1:0] cnt;
  ctl_t [NUM_CTR-1:0]            ctl;
  logic [NUM_CTR-1:0]            pmi;
  logic [NUM_CTR-1:0]            wrap;
  logic [NUM_CTR-1:0]            status;
  logic [NUM_CTR-1:0]            ctr_wr;
  logic [NUM_CTR-1:0]            ctl_wr;
  logic                          clr_we;
  logic                          frozen;
  logic                          run;

  assign run = glb_en & ~freeze_in & ~frozen;

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    evmon_ctr #(
      .CTR_W  (CTR_W),
      .INC_W  (INC_W),
      .MAX_INC(MAX_INC)
    ) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .run_i   (run),
      .ctr_wr_i(ctr_wr[i]),
      .ctl_wr_i(ctl_wr[i]),
      .wdata_i (reg_wdata),
      .inc_i   (event_inc[i*INC_W +: INC_W]),
      .cnt_o   (cnt[i]),
      .ctl_o   (ctl[i]),
      .wrap_o  (wrap[i])
    );
    assign pmi[i] = ctl[i].pmi_en;
  end

  evmon_stat #(.NUM_CTR(NUM_CTR)) u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .wrap_i    (wrap),
    .clr_we_i  (clr_we),
    .clr_mask_i(reg_wdata[NUM_CTR-1:0]),
    .pmi_i     (pmi),
    .glb_en_i  (glb_en),
    .status_o  (status),
    .frozen_o  (frozen),
    .ovf_o     (ovf_out),
    .irq_o     (irq_out)
  );

  evmon_regif #(
    .NUM_CTR(NUM_CTR),
    .CTR_W  (CTR_W),
    .ADDR_W (ADDR_W)
  ) u_regif (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr_i  (reg_wr),
    .reg_rd_i  (reg_rd),
    .reg_addr_i(reg_addr),
    .cnt_i     (cnt),
    .ctl_i     (ctl),
    .status_i  (status),
    .ctr_wr_o  (ctr_wr),
    .ctl_wr_o  (ctl_wr),
    .clr_we_o  (clr_we),
    .rdata_o   (reg_rdata)
  );

  // R9
  halt_after_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|wrap) && !reg_wr) |=> (wrap == '0));
endmodule

// File: tb/sim_evmon_bank.sv
module sim_evmon_bank;
  localparam int N  = 6;
  localparam int W  = 48;
  localparam int IW = 3;
  localparam int AW = 4;
  localparam logic [AW-1:0] A_STAT = 4'd12;
  localparam logic [AW-1:0] A_CLR  = 4'd13;
  localparam logic [W-1:0]  MAXV   = {W{1'b1}};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          glb_en = 1'b0;
  logic          freeze_in = 1'b0;
  logic [N*IW-1:0] event_inc = '0;
  logic          reg_wr = 1'b0;
  logic          reg_rd = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [W-1:0]  reg_wdata = '0;
  logic [W-1:0]  reg_rdata;
  logic          ovf_out;
  logic          irq_out;

  evmon_bank u0 (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .freeze_in(freeze_in),
    .event_inc(event_inc), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ovf_out(ovf_out), .irq_out(irq_out)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [W-1:0] exp_q[$];
  string        tag_q[$];
  logic         rd_q = 1'b0;

  always @(posedge clk) rd_q <= reg_rd;

  // monitor: each read result is due one edge after its strobe
  always @(negedge clk) begin
    if (rd_q && exp_q.size() > 0) begin
      logic [W-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (reg_rdata !== e) begin
        errors++;
        $display("FAIL %s rdata actual=%0h expected=%0h", t, reg_rdata, e);
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [W-1:0] e, input string t);
    reg_rd = 1'b1; reg_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic inc(input int idx, input logic [IW-1:0] v, input int n);
    event_inc[idx*IW +: IW] = v;
    repeat (n) @(negedge clk);
    event_inc = '0;
  endtask

  task automatic chk(input string t, input logic act, input logic e);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", t, act, e);
    end
  endtask

  task automatic finish_run();
    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 ovf_out", ovf_out, 1'b0);
    chk("R1 irq_out", irq_out, 1'b0);
    rd(4'd0, '0, "R1 counter0");
    rd(A_STAT, '0, "R1 status");
    rd(4'd6, '0, "R1 control0");
    // R2
    wr(4'd6, 48'd1);
    glb_en = 1'b1;
    inc(0, 3'd3, 4);
    rd(4'd0, 48'd12, "R2 counter0");
    // R3
    wr(4'd7, 48'd1);
    inc(1, 3'd7, 1);
    rd(4'd1, 48'd5, "R3 clamp");
    inc(1, 3'd6, 2);
    rd(4'd1, 48'd15, "R3 clamp6");
    // R4
    inc(2, 3'd5, 3);
    rd(4'd2, '0, "R4 local disabled");
    glb_en = 1'b0;
    inc(0, 3'd3, 2);
    rd(4'd0, 48'd12, "R4 global disabled");
    glb_en = 1'b1;
    // R5
    freeze_in = 1'b1;
    inc(0, 3'd3, 2);
    rd(4'd0, 48'd12, "R5 frozen counter0");
    rd(4'd1, 48'd15, "R5 frozen read counter1");
    freeze_in = 1'b0;
    inc(0, 3'd1, 1);
    rd(4'd0, 48'd13, "R5 after freeze");
    // R6
    wr(4'd3, MAXV - 48'd1);
    rd(4'd3, MAXV - 48'd1, "R6 preload");
    rd(A_STAT, '0, "R6 status after preload");
    chk("R6 ovf_out", ovf_out, 1'b0);
    event_inc[0 +: IW] = 3'd5;
    wr(4'd0, 48'd100);
    event_inc = '0;
    rd(4'd0, 48'd100, "R6 write wins");
    // R7, R8
    wr(4'd9, 48'd1);
    inc(3, 3'd4, 1);
    chk("R8 ovf_out", ovf_out, 1'b1);
    chk("R8 irq_out no pmi", irq_out, 1'b0);
    rd(4'd3, 48'd2, "R7 wrapped value");
    rd(A_STAT, 48'h08, "R7 status bit3");
    // R9
    inc(0, 3'd2, 3);
    rd(4'd0, 48'd100, "R9 halted");
    // R10
    wr(A_CLR, 48'h08);
    rd(A_STAT, '0, "R10 cleared");
    chk("R10 ovf_out", ovf_out, 1'b0);
    inc(0, 3'd2, 1);
    rd(4'd0, 48'd100, "R10 still halted");
    glb_en = 1'b0;
    @(negedge clk);
    glb_en = 1'b1;
    inc(0, 3'd2, 1);
    rd(4'd0, 48'd102, "R10 resumed");
    // R8 interrupt path
    wr(4'd10, 48'd3);
    wr(4'd4, MAXV);
    inc(4, 3'd1, 1);
    chk("R8 irq_out", irq_out, 1'b1);
    chk("R8 ovf_out pmi", ovf_out, 1'b1);
    rd(4'd4, '0, "R8 counter4 wrapped");
    wr(A_CLR, 48'h10);
    chk("R8 irq_out cleared", irq_out, 1'b0);
    glb_en = 1'b0;
    @(negedge clk);
    glb_en = 1'b1;
    // R11
    wr(4'd5, MAXV);
    wr(4'd11, 48'd1);
    event_inc[5*IW +: IW] = 3'd1;
    wr(A_CLR, 48'h20);
    event_inc = '0;
    rd(A_STAT, 48'h20, "R11 set wins");
    rd(4'd5, '0, "R11 counter5");
    chk("R11 ovf_out", ovf_out, 1'b1);
    done = 1;
    finish_run();
  end
endmodule